// File: doc/BRIEF.md
# Transfer Descriptor Vector Fetch Sequencer

This block turns a granted request vector number into a complete transfer descriptor. It does so in two levels of indirection. A start strobe carries a vector number. The block first forms the address of that vector's entry in a pointer table. The table base comes from a programmable register whose low ten bits are forced to zero. The block reads the 32-bit pointer held at that entry. It then reads the descriptor words at consecutive word addresses starting from the pointer.

A mode bit sets the descriptor length: three words in short mode and four words in full mode. All reads go over a simple word-read port. A request is held until the memory accepts it, and the data comes back later with a response-valid strobe. Only one read is outstanding at any time. When the last word arrives, the collected words are shown on a wide output and a one-cycle valid pulse is raised. A later stage interprets the fields and performs the transfer.

Top module: `desc_fetch_seq`

## Requirements
- R1: After reset `busy_o`, `rd_req_o` and `desc_valid_o` are low and `desc_words_o` is all zero.
- R2: A start accepted while idle samples `vec_i`, `tbl_base_i` and `short_mode_i`. The first read address is `(tbl_base_i with bits 9:0 cleared) + 4*vec_i`, so the low ten base bits have no effect.
- R3: After the table read returns pointer P, the descriptor reads go to `(P with bits 1:0 cleared)`, then +4, +8 and, in full mode, +12, in that order.
- R4: The number of descriptor reads per fetch is 3 when the sampled mode bit is 1 and 4 when it is 0.
- R5: At most one read is outstanding. `rd_req_o` stays low from the cycle a read is accepted (`rd_req_o && rd_ready_i`) until its `rsp_valid_i` arrives.
- R6: While `rd_req_o` is high and `rd_ready_i` is low, the request and `rd_addr_o` stay unchanged into the next cycle.
- R7: `desc_valid_o` is high for exactly one cycle, the cycle after the last descriptor word's response. Word i of the descriptor sits at `desc_words_o[32*i +: 32]`.
- R8: `start_i` has no effect while `busy_o` is high, including the valid cycle.
- R9: `rsp_valid_i` has no effect while no read is outstanding.
- R10: `desc_words_o` is cleared to zero when a start is accepted, and each slot is loaded as its word arrives. It then holds until the next accepted start, so slot 3 reads zero after a short-mode fetch.
- R11: `busy_o` is high from the cycle after an accepted start through the `desc_valid_o` cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe for a fetch |
| vec_i | input | VEC_W (8) | Granted vector number |
| tbl_base_i | input | DW (32) | Pointer table base address |
| short_mode_i | input | 1 | 1: three-word descriptor, 0: four-word descriptor |
| busy_o | output | 1 | Fetch in progress |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | DW (32) | Memory read byte address (word-aligned) |
| rd_ready_i | input | 1 | Memory accepts the request this cycle |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | DW (32) | Read data |
| desc_valid_o | output | 1 | One-cycle pulse: descriptor complete |
| desc_words_o | output | FULL_WORDS*DW (128) | Collected descriptor words, word 0 lowest |

## Verification
The bench uses table bases with every low bit set and pointers with random low bits. A design that did not clear those bits would issue misaligned or shifted addresses. Fetches alternate between short and full mode, and the vector runs to both ends of its range (0 and 255). A wrong length decision would cause an extra or missing read, or a stale fourth slot after a short fetch.

Memory acceptance and response latency vary from cycle to cycle. Start pulses arrive during busy cycles, including the valid cycle, and stray response strobes arrive while nothing is outstanding. A design that issued reads back to back, dropped a held request, restarted on a late start or latched a stray response would leave the reference model's per-cycle trace.

// File: rtl/dfs_pkg.sv
// Package: shared types for the descriptor fetch sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package dfs_pkg;

    // Sequencer phases; table read first, then the descriptor words.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_TBL_REQ  = 3'd1,
        ST_TBL_WAIT = 3'd2,
        ST_DSC_REQ  = 3'd3,
        ST_DSC_WAIT = 3'd4,
        ST_DONE     = 3'd5
    } fetch_st_e;

endpackage

// File: rtl/dfs_ctrl.sv
// Module: dfs_ctrl
// Sequences one table read and then SHORT_WORDS or FULL_WORDS descriptor
// reads. Only one read is in flight at a time. The mode bit is sampled
// when a start is accepted.
// Assumes: SHORT_WORDS <= FULL_WORDS, and IDX_W can hold FULL_WORDS-1.
module dfs_ctrl
    import dfs_pkg::*;
#(
    parameter int FULL_WORDS  = 4,
    parameter int SHORT_WORDS = 3,
    parameter int IDX_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             short_i,
    input  logic             rd_ready_i,
    input  logic             rsp_valid_i,
    output logic             accept_o,
    output logic             ptr_load_o,
    output logic             word_we_o,
    output logic [IDX_W-1:0] word_idx_o,
    output logic             tbl_phase_o,
    output logic             rd_req_o,
    output logic             busy_o,
    output logic             desc_valid_o
);

    localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(FULL_WORDS - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_WORDS - 1);

    fetch_st_e        state_q, state_d;
    logic             short_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;
    logic             last_word;

    assign accept_o   = (state_q == ST_IDLE) && start_i;
    assign ptr_load_o = (state_q == ST_TBL_WAIT) && rsp_valid_i;
    assign word_we_o  = (state_q == ST_DSC_WAIT) && rsp_valid_i;
    assign last_idx   = short_q ? LAST_SHORT : LAST_FULL;
    assign last_word  = (idx_q == last_idx);

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i)     state_d = ST_TBL_REQ;
            ST_TBL_REQ:  if (rd_ready_i)  state_d = ST_TBL_WAIT;
            ST_TBL_WAIT: if (rsp_valid_i) state_d = ST_DSC_REQ;
            ST_DSC_REQ:  if (rd_ready_i)  state_d = ST_DSC_WAIT;
            ST_DSC_WAIT: if (rsp_valid_i) state_d = last_word ? ST_DONE : ST_DSC_REQ;
            ST_DONE:                      state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Mode sample, taken at start acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)        short_q <= 1'b0;
        else if (accept_o) short_q <= short_i;
    end

    // Descriptor word index: cleared on pointer arrival, stepped per word.
    always_ff @(posedge clk) begin
        if (!rst_n)                      idx_q <= '0;
        else if (ptr_load_o)             idx_q <= '0;
        else if (word_we_o && !last_word) idx_q <= idx_q + 1'b1;
    end

    assign word_idx_o   = idx_q;
    assign tbl_phase_o  = (state_q == ST_TBL_REQ);
    assign rd_req_o     = (state_q == ST_TBL_REQ) || (state_q == ST_DSC_REQ);
    assign busy_o       = (state_q != ST_IDLE);
    assign desc_valid_o = (state_q == ST_DONE);

endmodule

// File: rtl/dfs_addr_gen.sv
// Module: dfs_addr_gen
// Holds the aligned table-entry address and the word-aligned descriptor
// pointer. It drives the read address for the current phase.
// Assumes: 4*(2**VEC_W - 1) fits below 2**ALIGN_BITS, so the entry stays
// inside the aligned table.
module dfs_addr_gen #(
    parameter int DW         = 32,
    parameter int VEC_W      = 8,
    parameter int IDX_W      = 2,
    parameter int ALIGN_BITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic [DW-1:0]    base_i,
    input  logic             ptr_load_i,
    input  logic [DW-1:0]    ptr_i,
    input  logic             tbl_phase_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [DW-1:0]    addr_o
);

    localparam logic [DW-1:0] BASE_MASK = ~DW'((64'd1 << ALIGN_BITS) - 64'd1);
    localparam logic [DW-1:0] WORD_MASK = ~DW'(3);

    logic [DW-1:0] entry_q;
    logic [DW-1:0] ptr_q;
    logic [DW-1:0] entry_d;

    assign entry_d = (base_i & BASE_MASK) + (DW'(vec_i) << 2);

    // Table-entry address, formed once per accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)        entry_q <= '0;
        else if (accept_i) entry_q <= entry_d;
    end

    // Descriptor pointer with its byte-offset bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr_q <= '0;
        else if (ptr_load_i) ptr_q <= ptr_i & WORD_MASK;
    end

    assign addr_o = tbl_phase_i ? entry_q : (ptr_q + (DW'(idx_i) << 2));

endmodule

// File: rtl/dfs_word_store.sv
// Module: dfs_word_store
// One register per descriptor slot. All slots clear on a new start, and
// the addressed slot loads when its word arrives.
// Assumes: idx_i < NWORDS whenever we_i is high.
module dfs_word_store #(
    parameter int DW     = 32,
    parameter int NWORDS = 4,
    parameter int IDX_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 we_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [DW-1:0]        data_i,
    output logic [NWORDS*DW-1:0] words_o
);

    for (genvar g = 0; g < NWORDS; g++) begin : g_slot
        logic [DW-1:0] slot_q;

        // Slot g: clear on start, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)                    slot_q <= '0;
            else if (we_i && (idx_i == IDX_W'(g)))    slot_q <= data_i;
        end

        assign words_o[g*DW +: DW] = slot_q;
    end

endmodule

// File: rtl/desc_fetch_seq.sv
// Module: desc_fetch_seq (top)
// Two-level fetch: vector number -> table entry -> descriptor words.
// Connects the sequencer, the address generator and the word store.
// Assumes: the memory answers every accepted read exactly once, later
// than the acceptance cycle.
module desc_fetch_seq #(
    parameter int DW          = 32,
    parameter int VEC_W       = 8,
    parameter int FULL_WORDS  = 4,
    parameter int SHORT_WORDS = 3,
    parameter int ALIGN_BITS  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [VEC_W-1:0]         vec_i,
    input  logic [DW-1:0]            tbl_base_i,
    input  logic                     short_mode_i,
    output logic                     busy_o,
    output logic                     rd_req_o,
    output logic [DW-1:0]            rd_addr_o,
    input  logic                     rd_ready_i,
    input  logic                     rsp_valid_i,
    input  logic [DW-1:0]            rsp_data_i,
    output logic                     desc_valid_o,
    output logic [FULL_WORDS*DW-1:0] desc_words_o
);

    localparam int IDX_W = (FULL_WORDS > 1) ? $clog2(FULL_WORDS) : 1;

    logic             accept;
    logic             ptr_load;
    logic             word_we;
    logic             tbl_phase;
    logic [IDX_W-1:0] word_idx;

    dfs_ctrl #(
        .FULL_WORDS (FULL_WORDS),
        .SHORT_WORDS(SHORT_WORDS),
        .IDX_W      (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .short_i     (short_mode_i),
        .rd_ready_i  (rd_ready_i),
        .rsp_valid_i (rsp_valid_i),
        .accept_o    (accept),
        .ptr_load_o  (ptr_load),
        .word_we_o   (word_we),
        .word_idx_o  (word_idx),
        .tbl_phase_o (tbl_phase),
        .rd_req_o    (rd_req_o),
        .busy_o      (busy_o),
        .desc_valid_o(desc_valid_o)
    );

    dfs_addr_gen #(
        .DW        (DW),
        .VEC_W     (VEC_W),
        .IDX_W     (IDX_W),
        .ALIGN_BITS(ALIGN_BITS)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .vec_i      (vec_i),
        .base_i     (tbl_base_i),
        .ptr_load_i (ptr_load),
        .ptr_i      (rsp_data_i),
        .tbl_phase_i(tbl_phase),
        .idx_i      (word_idx),
        .addr_o     (rd_addr_o)
    );

    dfs_word_store #(
        .DW    (DW),
        .NWORDS(FULL_WORDS),
        .IDX_W (IDX_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(accept),
        .we_i   (word_we),
        .idx_i  (word_idx),
        .data_i (rsp_data_i),
        .words_o(desc_words_o)
    );

endmodule

// File: rtl/desc_fetch_seq_chk.sv
// Module: desc_fetch_seq_chk
// Protocol checker bound to desc_fetch_seq. It tracks the outstanding read
// and the read count per fetch, and checks the handshake rules.
// Assumes: synchronous active-low reset shared with the design.
module desc_fetch_seq_chk #(
    parameter int DW          = 32,
    parameter int FULL_WORDS  = 4,
    parameter int SHORT_WORDS = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          short_mode_i,
    input logic          busy_o,
    input logic          rd_req_o,
    input logic [DW-1:0] rd_addr_o,
    input logic          rd_ready_i,
    input logic          rsp_valid_i,
    input logic          desc_valid_o
);

    logic       outstanding_q;
    logic       short_q;
    logic [7:0] reads_q;

    // Outstanding-read tracker.
    always_ff @(posedge clk) begin
        if (!rst_n)                      outstanding_q <= 1'b0;
        else if (rd_req_o && rd_ready_i) outstanding_q <= 1'b1;
        else if (rsp_valid_i)            outstanding_q <= 1'b0;
    end

    // Mode and read count of the current fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_q <= 1'b0;
            reads_q <= '0;
        end else if (start_i && !busy_o) begin
            short_q <= short_mode_i;
            reads_q <= '0;
        end else if (rd_req_o && rd_ready_i) begin
            reads_q <= reads_q + 8'd1;
        end
    end

    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o);

    a_r4_read_count: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |-> (reads_q == (short_q ? 8'(SHORT_WORDS + 1) : 8'(FULL_WORDS + 1))));

    a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding_q |-> !rd_req_o);

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o)));

    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |=> !desc_valid_o);

    a_r8_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !desc_valid_o) |=> busy_o);

    a_r11_valid_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |-> busy_o);

    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_o[1:0] == 2'b00));

endmodule

bind desc_fetch_seq desc_fetch_seq_chk #(
    .DW         (DW),
    .FULL_WORDS (FULL_WORDS),
    .SHORT_WORDS(SHORT_WORDS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .short_mode_i(short_mode_i),
    .busy_o      (busy_o),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_ready_i  (rd_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .desc_valid_o(desc_valid_o)
);

// File: tb/desc_fetch_seq_bench.sv
`timescale 1ns/1ps
module desc_fetch_seq_bench;

    localparam int DW    = 32;
    localparam int VEC_W = 8;
    localparam int NTXN  = 60;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i;
    logic [VEC_W-1:0] vec_i;
    logic [DW-1:0]    tbl_base_i;
    logic             short_mode_i;
    logic             busy_o;
    logic             rd_req_o;
    logic [DW-1:0]    rd_addr_o;
    logic             rd_ready_i;
    logic             rsp_valid_i;
    logic [DW-1:0]    rsp_data_i;
    logic             desc_valid_o;
    logic [4*DW-1:0]  desc_words_o;

    always #2.5 clk = ~clk;

    desc_fetch_seq u_desc_fetch_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_i(vec_i),
        .tbl_base_i(tbl_base_i), .short_mode_i(short_mode_i),
        .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ready_i(rd_ready_i), .rsp_valid_i(rsp_valid_i),
        .rsp_data_i(rsp_data_i), .desc_valid_o(desc_valid_o),
        .desc_words_o(desc_words_o)
    );

    int errors = 0;
    int checks = 0;

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5BD1_E995;
    endfunction

    function automatic logic [31:0] xs(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: phase 0 idle, 1 table request, 2 table wait,
    // 3 word request, 4 word wait, 5 valid cycle.
    int          m_ph = 0;
    logic [31:0] m_entry, m_ptr;
    int          m_k;
    bit          m_short;
    logic [31:0] m_words [4];
    // Memory responder state.
    bit          pend = 0;
    logic [31:0] paddr;
    int          dly;
    int          dsc_reads;

    initial begin
        logic [31:0] rng;
        logic [127:0] mw;
        int  txn, gap, stuck;
        bit  poke_prev, spur_prev, exp_req;

        rng = 32'h1ACE_B00C;
        txn = 0; gap = 2; stuck = 0; poke_prev = 0; spur_prev = 0;
        for (int i = 0; i < 4; i++) m_words[i] = '0;
        rst_n = 1'b0; start_i = 0; vec_i = '0; tbl_base_i = '0;
        short_mode_i = 0; rd_ready_i = 0; rsp_valid_i = 0; rsp_data_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy after reset", busy_o, 0);
        chk("R1 rd_req after reset", rd_req_o, 0);
        chk("R1 desc_valid after reset", desc_valid_o, 0);
        chk("R1 words after reset", desc_words_o, 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            // Compare against the model.
            mw = {m_words[3], m_words[2], m_words[1], m_words[0]};
            exp_req = (m_ph == 1) || (m_ph == 3);
            chk("R11 busy", busy_o, m_ph != 0);
            chk("R5/R6 rd_req", rd_req_o, exp_req);
            if (m_ph == 1) chk("R2 table entry address", rd_addr_o, m_entry);
            if (m_ph == 3) chk("R3 descriptor word address", rd_addr_o, m_ptr + 32'(4 * m_k));
            chk("R7 desc_valid", desc_valid_o, m_ph == 5);
            chk("R10 descriptor words", desc_words_o, mw);
            if (m_ph == 5) chk("R4 descriptor read count", 128'(dsc_reads), m_short ? 3 : 4);
            if (poke_prev) chk("R8 start while busy", {busy_o, rd_req_o}, {m_ph != 0, exp_req});
            if (spur_prev) chk("R9 stray response", {busy_o, rd_req_o, desc_valid_o, desc_words_o},
                               {m_ph != 0, exp_req, m_ph == 5, mw});
            if (m_ph != 0) stuck++; else stuck = 0;
            if (stuck > 300) begin
                errors++; checks++;
                $display("FAIL watchdog: fetch hung actual=%0d expected<=300", stuck);
                break;
            end
            if (txn >= NTXN && m_ph == 0 && !pend) break;

            // Drive inputs for the next edge.
            rng = xs(rng);
            spur_prev = 0;
            if (pend) begin
                if (dly == 0) begin
                    rsp_valid_i = 1; rsp_data_i = mem_word(paddr); pend = 0;
                end else begin
                    dly--; rsp_valid_i = 0; rsp_data_i = rng;
                end
            end else begin
                rsp_valid_i = (rng[3:0] == 4'd0);
                rsp_data_i  = rng ^ 32'hDEAD_BEEF;
                spur_prev   = rsp_valid_i;
            end
            rd_ready_i = (rng[5:4] != 2'b00);
            poke_prev = 0;
            if (m_ph == 0) begin
                if (gap == 0 && txn < NTXN) begin
                    start_i = 1;
                    case (txn)
                        0: begin vec_i = 8'd0;   tbl_base_i = 32'h0000_0000; short_mode_i = 1; end
                        1: begin vec_i = 8'd255; tbl_base_i = 32'hFFFF_FFFF; short_mode_i = 0; end
                        2: begin vec_i = 8'd1;   tbl_base_i = 32'h1234_57FF; short_mode_i = 1; end
                        3: begin vec_i = 8'd77;  tbl_base_i = 32'h8000_03A5; short_mode_i = 0; end
                        default: begin
                            vec_i = rng[23:16]; tbl_base_i = xs(rng); short_mode_i = rng[6];
                        end
                    endcase
                    txn++;
                    gap = int'(rng[8:7]);
                end else begin
                    start_i = 0;
                    if (gap > 0) gap--;
                    vec_i = rng[15:8];
                end
            end else begin
                start_i = (rng[10:9] == 2'b00);
                vec_i = rng[31:24]; tbl_base_i = ~rng; short_mode_i = rng[11];
                poke_prev = start_i;
            end
            if (rd_req_o && rd_ready_i) begin
                pend = 1; paddr = rd_addr_o; dly = int'(rng[13:12]);
                if (m_ph == 3) dsc_reads++;
            end

            // Advance the model to the state after the next edge.
            case (m_ph)
                0: if (start_i) begin
                       m_entry = (tbl_base_i & 32'hFFFF_FC00) + 32'(vec_i) * 4;
                       m_short = short_mode_i;
                       for (int i = 0; i < 4; i++) m_words[i] = '0;
                       dsc_reads = 0;
                       m_ph = 1;
                   end
                1: if (rd_ready_i) m_ph = 2;
                2: if (rsp_valid_i) begin m_ptr = rsp_data_i & 32'hFFFF_FFFC; m_k = 0; m_ph = 3; end
                3: if (rd_ready_i) m_ph = 4;
                4: if (rsp_valid_i) begin
                       m_words[m_k] = rsp_data_i;
                       if (m_k == (m_short ? 2 : 3)) m_ph = 5;
                       else begin m_k++; m_ph = 3; end
                   end
                default: m_ph = 0;
            endcase
        end
        if (txn < NTXN) begin
            errors++; checks++;
            $display("FAIL run incomplete actual=%0d expected=%0d fetches", txn, NTXN);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule